// File: doc/BRIEF.md
# Serial Port Interrupt Packetizer

This block sits on a shared bus with up to 128 serial port controllers and turns their interrupt requests into fixed 4-byte status packets. Each cycle it is idle, it picks a pending port in rotating order and reads that port's status register over the bus. If the status says a received character is waiting, it then reads the port's data register on its own.

It then writes the four bytes by DMA into a circular queue in memory. The queue belongs to the target processor that a writable port-to-target table names. There are up to eight targets. Each target has its own queue base, queue length in packets, a write slot the block advances, and a read slot the processor writes back.

A per-target notify line stays high while that queue holds unread packets. If a target's queue has no free slot, the port is left pending and not read, and a saturating per-target stall counter records each refused attempt. The table can be rewritten at any time, for example to move a port that has become busy from a shared idle-port target onto a lightly loaded one.

Top module: `sio_irq_packetizer`

## Requirements
- R1: After reset, busReqValid, dmaValid, every notify bit and every stall counter are 0. All routing entries select target 0. Target t has queue base t*4096, a length of DEF_SLOTS packets, and write and read slots of 0.
- R2: Pending ports are served one packet at a time in rotating order. A rotation pointer starts at 0 and, after each grant or refusal of port p, moves to p+1 (wrapping). The next port chosen is the lowest-numbered pending port at or above the pointer, or else the lowest-numbered pending port.
- R3: For a granted port, the first bus read is the status register (busRegSel=0) at busPort = port number. Only one bus read is outstanding at a time, and a request is held stable until busReqReady.
- R4: The data register (busRegSel=1) of the same port is read if and only if status bit 0 (receive data available) is set.
- R5: A packet is four DMA byte writes in the order: type, port number, status, data. The data byte is the value read from the data register, or 0x00 when no data read was made.
- R6: The type byte is 0x01 if status bit 0 is set, else 0x03 if bit 2 (line condition) is set, else 0x02 if bit 1 (transmit empty) is set, else 0x00.
- R7: A routing write sets the target of one port. Packets granted after the write go to the new target.
- R8: Byte i of the packet in slot s of target t goes to address base(t) + 4*s + i. After a packet, the slot advances by one and wraps from length-1 to 0. A queue configuration write sets base and length (length at least 2) and zeroes both slots.
- R9: When advancing the write slot of the chosen port's target would make it equal the read slot, the port's status is not read and its request stays pending. That target's stall counter increments by one per refused attempt and saturates at all ones. Once the processor frees a slot, the port is served.
- R10: A port refused for a full queue does not block ports routed to other targets.
- R11: notify[t] is 1 exactly when target t's write slot differs from its read slot.
- R12: A port whose request is still asserted after its status read is served again as a new event, in its rotating turn.
- R13: While dmaValid is 1 and dmaReady is 0, dmaValid, dmaAddr and dmaData hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portIrq | input | NUM_PORTS | Level interrupt request per port |
| busReqValid | output | 1 | Bus register read request |
| busReqReady | input | 1 | Bus accepts the read request |
| busPort | output | PORT_W | Port addressed by the read |
| busRegSel | output | 1 | 0 = status register, 1 = data register |
| busRspValid | input | 1 | Read data returned |
| busRspData | input | 8 | Returned register value |
| dmaValid | output | 1 | DMA byte write request |
| dmaReady | input | 1 | DMA accepts the byte |
| dmaAddr | output | ADDR_W | Byte address of the write |
| dmaData | output | 8 | Byte written |
| routeWrEn | input | 1 | Routing table write strobe |
| routeWrPort | input | PORT_W | Port whose entry is written |
| routeWrTgt | input | TGT_W | New target for that port |
| ringCfgEn | input | 1 | Queue configuration strobe |
| ringCfgTgt | input | TGT_W | Target being configured |
| ringCfgBase | input | ADDR_W | New queue base address |
| ringCfgSlots | input | SLOT_W | New queue length in packets |
| rdPtrWrEn | input | 1 | Read slot update strobe |
| rdPtrTgt | input | TGT_W | Target whose read slot is written |
| rdPtrVal | input | SLOT_W | New read slot |
| notify | output | NUM_TGT | Queue holds unread packets, per target |
| stallCounts | output | NUM_TGT*STALL_W | Saturating stall counters, target t at bits t*STALL_W upward |

## Verification
The checks assume a bus that returns exactly one response per accepted read, never unprompted. They also assume processor read-slot writes that never move the read slot past the write slot, and queue lengths of at least two. The bench's bus model answers each accepted read one cycle later and only then. The bench writes a read slot only after the packets before it have arrived, and it configures lengths of three or more. The port model drops a request at its status read unless a repeat count keeps it up, which is how re-assertion after a read is produced.

// File: rtl/sio_irq_pkg.sv
package sio_irq_pkg;

  // status register bit positions decoded by the packetizer
  localparam int RX_BIT   = 0;
  localparam int TX_BIT   = 1;
  localparam int LINE_BIT = 2;

  localparam logic [7:0] TYPE_OTHER = 8'h00;
  localparam logic [7:0] TYPE_RX    = 8'h01;
  localparam logic [7:0] TYPE_TX    = 8'h02;
  localparam logic [7:0] TYPE_LINE  = 8'h03;

  // strobes from control to datapath
  typedef struct packed {
    logic       grant;
    logic       stall;
    logic       capStat;
    logic       capData;
    logic       commit;
    logic [1:0] byteSel;
  } pk_strobe_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_STAT_REQ, ST_STAT_WAIT, ST_DATA_REQ, ST_DATA_WAIT, ST_WRITE
  } pk_state_t;

  function automatic logic [7:0] classifyStatus(input logic [7:0] st);
    if (st[RX_BIT])        return TYPE_RX;
    else if (st[LINE_BIT]) return TYPE_LINE;
    else if (st[TX_BIT])   return TYPE_TX;
    else                   return TYPE_OTHER;
  endfunction

endpackage

// File: rtl/sio_irq_rr_arb.sv
module sio_irq_rr_arb #(
  parameter int N = 128,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     req,
  input  logic [IDX_W-1:0] ptr,
  output logic             anyReq,
  output logic [IDX_W-1:0] pick
);
  logic [N-1:0]     upper;
  logic [IDX_W-1:0] pickHi, pickLo;

  always_comb begin
    for (int i = 0; i < N; i++) upper[i] = req[i] && (i >= int'(ptr));
    pickHi = '0;
    pickLo = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (upper[i]) pickHi = IDX_W'(i);
      if (req[i])   pickLo = IDX_W'(i);
    end
    anyReq = |req;
    pick   = (|upper) ? pickHi : pickLo;
  end
endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
  import sio_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       tgtFull,
  input  logic       busReqReady,
  input  logic       busRspValid,
  input  logic       rxNow,
  input  logic       dmaReady,
  output pk_strobe_t stb,
  output logic       busReqValid,
  output logic       busRegSel,
  output logic       dmaValid
);
  pk_state_t  state, stateNext;
  logic [1:0] byteCnt, byteCntNext;

  always_comb begin
    stateNext   = state;
    byteCntNext = byteCnt;
    stb         = '0;
    stb.byteSel = byteCnt;
    unique case (state)
      ST_IDLE: begin
        if (anyReq) begin
          if (tgtFull) stb.stall = 1'b1;
          else begin
            stb.grant = 1'b1;
            stateNext = ST_STAT_REQ;
          end
        end
      end
      ST_STAT_REQ:  if (busReqReady) stateNext = ST_STAT_WAIT;
      ST_STAT_WAIT: begin
        if (busRspValid) begin
          stb.capStat = 1'b1;
          stateNext   = rxNow ? ST_DATA_REQ : ST_WRITE;
        end
      end
      ST_DATA_REQ:  if (busReqReady) stateNext = ST_DATA_WAIT;
      ST_DATA_WAIT: begin
        if (busRspValid) begin
          stb.capData = 1'b1;
          stateNext   = ST_WRITE;
        end
      end
      ST_WRITE: begin
        if (dmaReady) begin
          if (byteCnt == 2'd3) begin
            stb.commit  = 1'b1;
            byteCntNext = 2'd0;
            stateNext   = ST_IDLE;
          end else begin
            byteCntNext = byteCnt + 2'd1;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      byteCnt <= 2'd0;
    end else begin
      state   <= stateNext;
      byteCnt <= byteCntNext;
    end
  end

  assign busReqValid = (state == ST_STAT_REQ) || (state == ST_DATA_REQ);
  assign busRegSel   = (state == ST_DATA_REQ);
  assign dmaValid    = (state == ST_WRITE);
endmodule

// File: rtl/sio_irq_datapath.sv
module sio_irq_datapath
  import sio_irq_pkg::*;
#(
  parameter int NUM_PORTS  = 128,
  parameter int NUM_TGT    = 8,
  parameter int ADDR_W     = 32,
  parameter int SLOT_W     = 8,
  parameter int STALL_W    = 8,
  parameter int DEF_SLOTS  = 129,
  parameter int BASE_SHIFT = 12,
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int TGT_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  pk_strobe_t                 stb,
  input  logic [PORT_W-1:0]          pick,
  input  logic [7:0]                 busRspData,
  input  logic                       routeWrEn,
  input  logic [PORT_W-1:0]          routeWrPort,
  input  logic [TGT_W-1:0]           routeWrTgt,
  input  logic                       ringCfgEn,
  input  logic [TGT_W-1:0]           ringCfgTgt,
  input  logic [ADDR_W-1:0]          ringCfgBase,
  input  logic [SLOT_W-1:0]          ringCfgSlots,
  input  logic                       rdPtrWrEn,
  input  logic [TGT_W-1:0]           rdPtrTgt,
  input  logic [SLOT_W-1:0]          rdPtrVal,
  output logic                       tgtFull,
  output logic [PORT_W-1:0]          rrPtr,
  output logic [PORT_W-1:0]          curPort,
  output logic [ADDR_W-1:0]          dmaAddr,
  output logic [7:0]                 dmaData,
  output logic [NUM_TGT-1:0]         notify,
  output logic [NUM_TGT*STALL_W-1:0] stallCounts
);
  logic [TGT_W-1:0]   routeTbl [NUM_PORTS];
  logic [ADDR_W-1:0]  ringBase [NUM_TGT];
  logic [SLOT_W-1:0]  ringSlots[NUM_TGT];
  logic [SLOT_W-1:0]  wrSlot   [NUM_TGT];
  logic [SLOT_W-1:0]  rdSlot   [NUM_TGT];
  logic [SLOT_W-1:0]  wrNext   [NUM_TGT];
  logic [STALL_W-1:0] stallCnt [NUM_TGT];
  logic [NUM_TGT-1:0] ringFull;

  logic [TGT_W-1:0] pickTgt, curTgt;
  logic [7:0]       statReg, dataReg;
  logic [PORT_W-1:0] pickPlusOne;

  assign pickTgt     = routeTbl[pick];
  assign tgtFull     = ringFull[pickTgt];
  assign pickPlusOne = (int'(pick) == NUM_PORTS - 1) ? '0 : pick + PORT_W'(1);

  // ring occupancy per target
  always_comb begin
    for (int t = 0; t < NUM_TGT; t++) begin
      wrNext[t]   = (wrSlot[t] + SLOT_W'(1) == ringSlots[t]) ? '0 : wrSlot[t] + SLOT_W'(1);
      ringFull[t] = (wrNext[t] == rdSlot[t]);
    end
  end

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_tgtOut
    assign notify[g] = (wrSlot[g] != rdSlot[g]);
    assign stallCounts[g*STALL_W +: STALL_W] = stallCnt[g];
  end

  // routing table
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PORTS; p++) routeTbl[p] <= '0;
    end else if (routeWrEn) begin
      routeTbl[routeWrPort] <= routeWrTgt;
    end
  end

  // per-target queue state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int t = 0; t < NUM_TGT; t++) begin
        ringBase[t]  <= ADDR_W'(t) << BASE_SHIFT;
        ringSlots[t] <= SLOT_W'(DEF_SLOTS);
        wrSlot[t]    <= '0;
        rdSlot[t]    <= '0;
        stallCnt[t]  <= '0;
      end
    end else begin
      for (int t = 0; t < NUM_TGT; t++) begin
        if (stb.stall && pickTgt == TGT_W'(t) && stallCnt[t] != '1)
          stallCnt[t] <= stallCnt[t] + STALL_W'(1);
        if (ringCfgEn && ringCfgTgt == TGT_W'(t)) begin
          ringBase[t]  <= ringCfgBase;
          ringSlots[t] <= ringCfgSlots;
          wrSlot[t]    <= '0;
          rdSlot[t]    <= '0;
        end else begin
          if (rdPtrWrEn && rdPtrTgt == TGT_W'(t)) rdSlot[t] <= rdPtrVal;
          if (stb.commit && curTgt == TGT_W'(t))  wrSlot[t] <= wrNext[t];
        end
      end
    end
  end

  // grant bookkeeping and captured register values
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrPtr   <= '0;
      curPort <= '0;
      curTgt  <= '0;
      statReg <= '0;
      dataReg <= '0;
    end else begin
      if (stb.grant || stb.stall) rrPtr <= pickPlusOne;
      if (stb.grant) begin
        curPort <= pick;
        curTgt  <= pickTgt;
      end
      if (stb.capStat) begin
        statReg <= busRspData;
        dataReg <= '0;
      end
      if (stb.capData) dataReg <= busRspData;
    end
  end

  // byte s*4+i of the target queue
  assign dmaAddr = ringBase[curTgt] +
                   {{(ADDR_W-SLOT_W-2){1'b0}}, wrSlot[curTgt], stb.byteSel};

  always_comb begin
    unique case (stb.byteSel)
      2'd0:    dmaData = classifyStatus(statReg);
      2'd1:    dmaData = 8'(curPort);
      2'd2:    dmaData = statReg;
      default: dmaData = dataReg;
    endcase
  end
endmodule

// File: rtl/sio_irq_packetizer.sv
module sio_irq_packetizer
  import sio_irq_pkg::*;
#(
  parameter int NUM_PORTS  = 128,
  parameter int NUM_TGT    = 8,
  parameter int ADDR_W     = 32,
  parameter int SLOT_W     = 8,
  parameter int STALL_W    = 8,
  parameter int DEF_SLOTS  = 129,
  parameter int BASE_SHIFT = 12,
  localparam int PORT_W = $clog2(NUM_PORTS),
  localparam int TGT_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PORTS-1:0]       portIrq,
  output logic                       busReqValid,
  input  logic                       busReqReady,
  output logic [PORT_W-1:0]          busPort,
  output logic                       busRegSel,
  input  logic                       busRspValid,
  input  logic [7:0]                 busRspData,
  output logic                       dmaValid,
  input  logic                       dmaReady,
  output logic [ADDR_W-1:0]          dmaAddr,
  output logic [7:0]                 dmaData,
  input  logic                       routeWrEn,
  input  logic [PORT_W-1:0]          routeWrPort,
  input  logic [TGT_W-1:0]           routeWrTgt,
  input  logic                       ringCfgEn,
  input  logic [TGT_W-1:0]           ringCfgTgt,
  input  logic [ADDR_W-1:0]          ringCfgBase,
  input  logic [SLOT_W-1:0]          ringCfgSlots,
  input  logic                       rdPtrWrEn,
  input  logic [TGT_W-1:0]           rdPtrTgt,
  input  logic [SLOT_W-1:0]          rdPtrVal,
  output logic [NUM_TGT-1:0]         notify,
  output logic [NUM_TGT*STALL_W-1:0] stallCounts
);
  pk_strobe_t        stb;
  logic              anyReq, tgtFull;
  logic [PORT_W-1:0] pick, rrPtr;

  sio_irq_rr_arb #(.N(NUM_PORTS)) u_arb (
    .req(portIrq), .ptr(rrPtr), .anyReq(anyReq), .pick(pick)
  );

  sio_irq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .anyReq(anyReq), .tgtFull(tgtFull),
    .busReqReady(busReqReady), .busRspValid(busRspValid),
    .rxNow(busRspData[RX_BIT]), .dmaReady(dmaReady), .stb(stb),
    .busReqValid(busReqValid), .busRegSel(busRegSel), .dmaValid(dmaValid)
  );

  sio_irq_datapath #(
    .NUM_PORTS(NUM_PORTS), .NUM_TGT(NUM_TGT), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W),
    .STALL_W(STALL_W), .DEF_SLOTS(DEF_SLOTS), .BASE_SHIFT(BASE_SHIFT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .pick(pick), .busRspData(busRspData),
    .routeWrEn(routeWrEn), .routeWrPort(routeWrPort), .routeWrTgt(routeWrTgt),
    .ringCfgEn(ringCfgEn), .ringCfgTgt(ringCfgTgt), .ringCfgBase(ringCfgBase),
    .ringCfgSlots(ringCfgSlots), .rdPtrWrEn(rdPtrWrEn), .rdPtrTgt(rdPtrTgt),
    .rdPtrVal(rdPtrVal), .tgtFull(tgtFull), .rrPtr(rrPtr), .curPort(busPort),
    .dmaAddr(dmaAddr), .dmaData(dmaData), .notify(notify), .stallCounts(stallCounts)
  );
endmodule

// File: rtl/sio_irq_checker.sv
module sio_irq_checker #(
  parameter int NUM_PORTS = 128,
  parameter int NUM_TGT   = 8,
  parameter int ADDR_W    = 32,
  parameter int STALL_W   = 8,
  localparam int PORT_W = $clog2(NUM_PORTS)
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       busReqValid,
  input logic                       busReqReady,
  input logic [PORT_W-1:0]          busPort,
  input logic                       busRegSel,
  input logic                       busRspValid,
  input logic                       rspRx,
  input logic                       dmaValid,
  input logic                       dmaReady,
  input logic [ADDR_W-1:0]          dmaAddr,
  input logic [7:0]                 dmaData,
  input logic [NUM_TGT*STALL_W-1:0] stallCounts
);
  logic              outstanding, reqSelHeld, lastWasStatus, lastRx;
  logic [PORT_W-1:0] reqPortHeld, lastPort;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outstanding   <= 1'b0;
      reqSelHeld    <= 1'b0;
      reqPortHeld   <= '0;
      lastWasStatus <= 1'b0;
      lastRx        <= 1'b0;
      lastPort      <= '0;
    end else begin
      if (busReqValid && busReqReady) begin
        outstanding <= 1'b1;
        reqSelHeld  <= busRegSel;
        reqPortHeld <= busPort;
      end else if (busRspValid) begin
        outstanding   <= 1'b0;
        lastWasStatus <= !reqSelHeld;
        lastRx        <= rspRx && !reqSelHeld;
        lastPort      <= reqPortHeld;
      end
    end
  end

  // R3: a single read in flight
  a_r3_one_outstanding: assert property (@(posedge clk) disable iff (!rstN)
    !(outstanding && busReqValid));

  // R3: a stalled read request holds
  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid && !busReqReady |=> busReqValid && $stable(busPort) && $stable(busRegSel));

  // R4: data read only right after a receive-ready status of the same port
  a_r4_data_after_rx: assert property (@(posedge clk) disable iff (!rstN)
    busReqValid && busRegSel |-> lastWasStatus && lastRx && (busPort == lastPort));

  // R13: DMA byte held under backpressure
  a_r13_dma_hold: assert property (@(posedge clk) disable iff (!rstN)
    dmaValid && !dmaReady |=> dmaValid && $stable(dmaAddr) && $stable(dmaData));

  // R3, R5: bus reads and DMA writes never overlap
  a_r5_bus_dma_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(dmaValid && busReqValid));

  // R9: stall counters only count up or saturate
  for (genvar g = 0; g < NUM_TGT; g++) begin : g_stall
    a_r9_stall_monotonic: assert property (@(posedge clk) disable iff (!rstN)
      stallCounts[g*STALL_W +: STALL_W] >= $past(stallCounts[g*STALL_W +: STALL_W]));
  end
endmodule

bind sio_irq_packetizer sio_irq_checker #(
  .NUM_PORTS(NUM_PORTS), .NUM_TGT(NUM_TGT), .ADDR_W(ADDR_W), .STALL_W(STALL_W)
) u_chk (
  .clk(clk), .rstN(rstN), .busReqValid(busReqValid), .busReqReady(busReqReady),
  .busPort(busPort), .busRegSel(busRegSel), .busRspValid(busRspValid),
  .rspRx(busRspData[0]), .dmaValid(dmaValid), .dmaReady(dmaReady),
  .dmaAddr(dmaAddr), .dmaData(dmaData), .stallCounts(stallCounts)
);

// File: tb/tb_sio_irq_packetizer.sv
`timescale 1ns/1ps
module tb_sio_irq_packetizer;
  localparam int NP = 128;
  localparam int NT = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2 clk = ~clk;

  logic [NP-1:0]   portIrq = '0;
  logic            busReqValid, busRegSel, dmaValid;
  logic            busReqReady = 1'b1;
  logic [6:0]      busPort;
  logic            busRspValid = 1'b0;
  logic [7:0]      busRspData = '0;
  logic            dmaReady = 1'b1;
  logic [31:0]     dmaAddr;
  logic [7:0]      dmaData;
  logic            routeWrEn = 1'b0;
  logic [6:0]      routeWrPort = '0;
  logic [2:0]      routeWrTgt = '0;
  logic            ringCfgEn = 1'b0;
  logic [2:0]      ringCfgTgt = '0;
  logic [31:0]     ringCfgBase = '0;
  logic [7:0]      ringCfgSlots = '0;
  logic            rdPtrWrEn = 1'b0;
  logic [2:0]      rdPtrTgt = '0;
  logic [7:0]      rdPtrVal = '0;
  logic [NT-1:0]   notify;
  logic [NT*8-1:0] stallCounts;

  sio_irq_packetizer dut (.*);

  logic [7:0] portStat [NP];
  logic [7:0] portData [NP];
  int         stickyLeft [NP];
  logic [31:0] logAddr [$];
  logic [7:0]  logData [$];
  int          statLog [$];
  int          dataLog [$];
  logic        throttle = 1'b0;
  int          nChecks = 0, nFail = 0, pktIdx = 0;

  // bus slave: answers one cycle after the accepted request
  initial begin
    logic       pend;
    logic [7:0] pendByte;
    pend = 1'b0; pendByte = '0;
    for (int i = 0; i < NP; i++) begin portStat[i] = '0; portData[i] = '0; stickyLeft[i] = 0; end
    forever begin
      @(negedge clk);
      busRspValid = 1'b0;
      if (pend) begin busRspValid = 1'b1; busRspData = pendByte; pend = 1'b0; end
      if (busReqValid && busReqReady) begin
        pend = 1'b1;
        if (!busRegSel) begin
          pendByte = portStat[busPort];
          statLog.push_back(int'(busPort));
          if (stickyLeft[busPort] > 0) stickyLeft[busPort]--;
          else portIrq[busPort] = 1'b0;
        end else begin
          pendByte = portData[busPort];
          dataLog.push_back(int'(busPort));
        end
      end
    end
  end

  // DMA sink
  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      dmaReady = throttle ? (cyc % 3 == 0) : 1'b1;
      if (dmaValid && dmaReady) begin logAddr.push_back(dmaAddr); logData.push_back(dmaData); end
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  task automatic fire(input int p, input logic [7:0] st, input logic [7:0] d, input int sticky);
    @(negedge clk);
    portStat[p] = st; portData[p] = d; stickyLeft[p] = sticky;
    portIrq[p] = 1'b1;
  endtask

  task automatic setRoute(input int p, input int t);
    @(negedge clk); routeWrEn = 1'b1; routeWrPort = 7'(p); routeWrTgt = 3'(t);
    @(negedge clk); routeWrEn = 1'b0;
  endtask

  task automatic setRd(input int t, input int v);
    @(negedge clk); rdPtrWrEn = 1'b1; rdPtrTgt = 3'(t); rdPtrVal = 8'(v);
    @(negedge clk); rdPtrWrEn = 1'b0;
  endtask

  task automatic waitPkts(input int n);
    for (int i = 0; i < 4000 && logAddr.size() < 4 * n; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  // compares the next logged packet
  task automatic expectPkt(input string req, input logic [31:0] addr,
                           input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] b3);
    logic [7:0] exp [4];
    exp[0] = b0; exp[1] = b1; exp[2] = b2; exp[3] = b3;
    if (logAddr.size() < 4 * pktIdx + 4) begin
      chk({req, " packet missing"}, 64'(logAddr.size()), 64'(4 * pktIdx + 4));
    end else begin
      for (int k = 0; k < 4; k++) begin
        chk({req, " addr"}, 64'(logAddr[4*pktIdx+k]), 64'(addr + 32'(k)));
        chk({req, " byte"}, 64'(logData[4*pktIdx+k]), 64'(exp[k]));
      end
    end
    pktIdx++;
  endtask

  task automatic tReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 busReqValid", 64'(busReqValid), 0);
    chk("R1 dmaValid", 64'(dmaValid), 0);
    chk("R1 notify", 64'(notify), 0);
    chk("R1 stallCounts", 64'(stallCounts), 0);
  endtask

  task automatic tRxPacket();
    setRoute(5, 2);
    fire(5, 8'h01, 8'hA5, 0);
    waitPkts(1);
    expectPkt("R5 R4 rx packet", 32'h2000, 8'h01, 8'h05, 8'h01, 8'hA5);
    chk("R4 one data read", 64'(dataLog.size()), 1);
    chk("R11 notify set", 64'(notify[2]), 1);
    setRd(2, 1);
    @(negedge clk);
    chk("R11 notify clear", 64'(notify[2]), 0);
  endtask

  task automatic tTypes();
    fire(9, 8'h02, 8'h11, 0);  waitPkts(2);
    expectPkt("R6 tx type", 32'h0000, 8'h02, 8'h09, 8'h02, 8'h00);
    fire(12, 8'h06, 8'h22, 0); waitPkts(3);
    expectPkt("R6 line type", 32'h0004, 8'h03, 8'h0C, 8'h06, 8'h00);
    fire(40, 8'h80, 8'h33, 0); waitPkts(4);
    expectPkt("R6 other type", 32'h0008, 8'h00, 8'h28, 8'h80, 8'h00);
    chk("R4 no data read without rx", 64'(dataLog.size()), 1);
    fire(41, 8'h05, 8'h3C, 0); waitPkts(5);
    expectPkt("R6 rx over line", 32'h000C, 8'h01, 8'h29, 8'h05, 8'h3C);
    chk("R3 status read first", 64'(statLog[statLog.size()-1]), 41);
  endtask

  task automatic tRoundRobin();
    // pointer now 42: order 60, 100, 3
    @(negedge clk);
    portStat[3] = 8'h02; portStat[60] = 8'h02; portStat[100] = 8'h02;
    portIrq[3] = 1'b1; portIrq[60] = 1'b1; portIrq[100] = 1'b1;
    waitPkts(8);
    expectPkt("R2 rr first", 32'h0010, 8'h02, 8'd60, 8'h02, 8'h00);
    expectPkt("R2 rr second", 32'h0014, 8'h02, 8'd100, 8'h02, 8'h00);
    expectPkt("R2 rr wrap", 32'h0018, 8'h02, 8'd3, 8'h02, 8'h00);
  endtask

  task automatic tRepeat();
    // pointer now 4: port 7 stays up for two extra reads
    @(negedge clk);
    portStat[7] = 8'h02; stickyLeft[7] = 2; portStat[20] = 8'h02; stickyLeft[20] = 0;
    portIrq[7] = 1'b1; portIrq[20] = 1'b1;
    waitPkts(12);
    expectPkt("R12 first", 32'h001C, 8'h02, 8'd7, 8'h02, 8'h00);
    expectPkt("R12 other port turn", 32'h0020, 8'h02, 8'd20, 8'h02, 8'h00);
    expectPkt("R12 repeat", 32'h0024, 8'h02, 8'd7, 8'h02, 8'h00);
    expectPkt("R12 repeat again", 32'h0028, 8'h02, 8'd7, 8'h02, 8'h00);
    chk("R12 request dropped", 64'(portIrq[7]), 0);
  endtask

  task automatic tReroute();
    setRoute(5, 4);
    fire(5, 8'h01, 8'h77, 0);
    waitPkts(13);
    expectPkt("R7 new target", 32'h4000, 8'h01, 8'h05, 8'h01, 8'h77);
    chk("R7 old target untouched", 64'(notify[2]), 0);
  endtask

  task automatic tFull();
    @(negedge clk);
    ringCfgEn = 1'b1; ringCfgTgt = 3'd6; ringCfgBase = 32'h0000_6800; ringCfgSlots = 8'd3;
    @(negedge clk); ringCfgEn = 1'b0;
    setRoute(30, 6);
    setRoute(31, 1);
    fire(30, 8'h02, 8'h00, 0); waitPkts(14);
    expectPkt("R8 slot0", 32'h6800, 8'h02, 8'd30, 8'h02, 8'h00);
    fire(30, 8'h02, 8'h00, 0); waitPkts(15);
    expectPkt("R8 slot1", 32'h6804, 8'h02, 8'd30, 8'h02, 8'h00);
    fire(30, 8'h02, 8'h00, 0);
    fire(31, 8'h02, 8'h00, 0);
    waitPkts(16);
    expectPkt("R10 other target served", 32'h1000, 8'h02, 8'd31, 8'h02, 8'h00);
    repeat (20) @(negedge clk);
    chk("R9 no write when full", 64'(logAddr.size()), 64'(4 * 16));
    chk("R9 request kept", 64'(portIrq[30]), 1);
    chk("R9 stall counted", 64'(stallCounts[6*8 +: 8] != 0), 1);
    chk("R9 other stall zero", 64'(stallCounts[1*8 +: 8]), 0);
    setRd(6, 2);
    waitPkts(17);
    expectPkt("R9 served after free", 32'h6808, 8'h02, 8'd30, 8'h02, 8'h00);
    chk("R11 notify after wrap", 64'(notify[6]), 1);
    setRd(6, 0);
    @(negedge clk);
    chk("R11 notify drained", 64'(notify[6]), 0);
    fire(30, 8'h02, 8'h00, 0); waitPkts(18);
    expectPkt("R8 wrapped slot", 32'h6800, 8'h02, 8'd30, 8'h02, 8'h00);
  endtask

  task automatic tBackpressure();
    throttle = 1'b1;
    fire(50, 8'h01, 8'hC3, 0);
    waitPkts(19);
    expectPkt("R13 throttled packet", 32'h002C, 8'h01, 8'd50, 8'h01, 8'hC3);
    throttle = 1'b0;
  endtask

  initial begin
    fork
      begin
        repeat (200000) @(posedge clk);
        nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
      end
    join_none
    tReset();
    tRxPacket();
    tTypes();
    tRoundRobin();
    tRepeat();
    tReroute();
    tFull();
    tBackpressure();
    summary();
    $finish;
  end
endmodule